// File: doc/BRIEF.md
# Selectable Half-Band Interpolator for a Transmit DAC Path

This block sits in front of a transmit DAC. It takes signed 12-bit samples at the input word rate and raises the sample rate by one, two or four. Doubling uses a long half-band low-pass stage with 43 taps. Quadrupling adds a short 11-tap half-band stage after the first one, running at the doubled rate. In the one-times setting both stages are bypassed. A 2-bit setting input selects the factor. One of its four codes is reserved and silences the block.

The whole block runs on one fast clock. An input strobe marks each new input word, and an output strobe marks each produced sample. Because each stage is a half-band filter, every second coefficient is zero. One output phase is therefore a plain delayed copy of the input, and only the other phase needs multipliers. Each stage rounds its result and saturates it back to 12 bits. Changing the setting clears every delay line, so no history from one mode leaks into the next.

The clock must run at least four times the input word rate in the four-times setting and at least twice the input word rate in the two-times setting. This matches an input word rate of up to 80 MSPS and an update rate of up to 200 MSPS, so the four-times setting suits inputs of 50 MSPS or less.

Top module: `hb_interp_tx`

## Requirements
- R1: The setting code selects the factor: 00 selects 4x, 01 selects 2x and 10 selects 1x. Each accepted input strobe produces exactly 4, 2 or 1 output strobes respectively.
- R2: Setting code 11 is reserved. While it is held, the output strobe stays low and input strobes have no effect.
- R3: In the 1x setting, the output strobe rises one clock after the input strobe, and the output carries the input word unchanged.
- R4: In the 2x setting, the output is the input zero-stuffed by two and convolved with a 43-tap half-band filter. Its centre tap is 32768. Its odd offsets ±1, ±3, …, ±21 carry 20751, -6639, 3663, -2294, 1488, -947, 577, -319, 149, -50 and 5, in that order. Every other even offset is zero. Each result is divided by 2^15 with round-half-up: 16384 is added, then the value is shifted right arithmetically by 15.
- R5: In the 4x setting, the 2x result (rounded and saturated) is interpolated again by an 11-tap half-band filter. Its centre tap is 32768, and its offsets ±1, ±3, ±5 carry 19200, -3200 and 384. The same rounding is used.
- R6: Output order and latency are fixed per setting. An isolated input impulse reappears unchanged at output index 0 in the 1x setting, at index 21 in the 2x setting and at index 47 in the 4x setting. Output indices count output strobes from the first input.
- R7: Each stage saturates its rounded result to the range -2048 to 2047.
- R8: A change of the setting code clears every delay line and every pending output. An input strobe in the same cycle as the change is dropped.
- R9: Input strobes must be spaced at least 2 clocks apart in the 2x setting and at least 4 clocks apart in the 4x setting. Any larger or irregular spacing yields the same output values.
- R10: During and right after reset, the output strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Factor setting: 00=4x, 01=2x, 10=1x, 11=reserved |
| in_vld | input | 1 | Input word strobe |
| in_data | input | 12 | Signed input word |
| out_vld | output | 1 | Output sample strobe |
| out_data | output | 12 | Signed output sample |

## Verification
A change of setting can fall in the same cycle as an input strobe, so the clear and the sample capture compete. The bench first leaves non-zero history in the 2x delay lines. It then switches to 4x while strobing a large word in the same cycle, and expects only zeros from the trailing zero inputs. Within a stage, the pending centre-phase output can also meet the next input when strobes come at the minimum spacing. This is provoked by bursts at spacing 2 (2x) and spacing 4 (4x), and every sample is judged against a reference convolution.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  typedef enum logic [1:0] {
    M_X4  = 2'b00,
    M_X2  = 2'b01,
    M_X1  = 2'b10,
    M_RSV = 2'b11
  } hb_mode_e;

  // Odd-phase coefficients, Q15 with gain 2 folded in; k = 0 is nearest the centre.
  // sel 0: long stage (43 taps), sel 1: short stage (11 taps). Each set sums to 16384.
  function automatic int hb_coef(input int sel, input int k);
    if (sel == 0) begin
      case (k)
        0: return 20751;   1: return -6639;   2: return 3663;
        3: return -2294;   4: return 1488;    5: return -947;
        6: return 577;     7: return -319;    8: return 149;
        9: return -50;     10: return 5;
        default: return 0;
      endcase
    end else begin
      case (k)
        0: return 19200;   1: return -3200;   2: return 384;
        default: return 0;
      endcase
    end
  endfunction

  // Round half up by 2^frac, then clamp to a signed dw-bit range.
  function automatic logic signed [31:0] hb_round_sat(input logic signed [63:0] acc,
                                                      input int frac, input int dw);
    logic signed [63:0] r, hi, lo;
    hi = (64'sd1 <<< (dw - 1)) - 64'sd1;
    lo = -(64'sd1 <<< (dw - 1));
    r  = (acc + (64'sd1 <<< (frac - 1))) >>> frac;
    if (r > hi)      r = hi;
    else if (r < lo) r = lo;
    return r[31:0];
  endfunction

endpackage

// File: rtl/hbi_ctrl.sv
module hbi_ctrl
  import hbi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       in_vld,
  output hb_mode_e   mode_q,
  output logic       flush,
  output logic       en_s1,
  output logic       en_byp,
  output logic       gap2
);
  hb_mode_e mode_e;
  assign mode_e = hb_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= M_RSV;
    else        mode_q <= mode_e;
  end

  assign flush  = (mode_e != mode_q);
  assign en_s1  = in_vld && !flush && ((mode_e == M_X4) || (mode_e == M_X2));
  assign en_byp = in_vld && !flush && (mode_e == M_X1);
  assign gap2   = (mode_e == M_X4);

  // R8
  chg_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e != $past(mode_e)) |-> flush);
endmodule

// File: rtl/hbi_stage.sv
module hbi_stage
  import hbi_pkg::*;
#(
  parameter int DW   = 12,
  parameter int CW   = 16,
  parameter int NTAP = 43,
  parameter int SEL  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 gap2,
  input  logic                 i_vld,
  input  logic signed [DW-1:0] i_dat,
  output logic                 o_vld,
  output logic signed [DW-1:0] o_dat
);
  localparam int L     = (NTAP + 1) / 2;
  localparam int K     = L / 2;
  localparam int CIDX  = K - 1;
  localparam int FRAC  = CW - 1;
  localparam int ACC_W = DW + CW + 2 + $clog2(K);

  logic signed [DW-1:0]    dly [L];
  logic signed [ACC_W-1:0] acc;
  logic signed [DW-1:0]    sum_rs;
  logic signed [DW-1:0]    pend;
  logic                    p1;
  logic [1:0]              wt;
  logic                    emit_sum, emit_ctr;

  // newest sample at dly[0]
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int j = 0; j < L; j++) dly[j] <= '0;
    end else if (i_vld) begin
      dly[0] <= i_dat;
      for (int j = 1; j < L; j++) dly[j] <= dly[j-1];
    end
  end

  // folded symmetric sum over the nonzero taps only
  always_comb begin
    acc = '0;
    for (int k = 0; k < K; k++)
      acc = acc + ACC_W'(hb_coef(SEL, k)) *
                  (ACC_W'(dly[K-1-k]) + ACC_W'(dly[K+k]));
  end

  assign sum_rs   = DW'(hb_round_sat(64'(acc), FRAC, DW));
  assign emit_sum = p1;
  assign emit_ctr = (wt == 2'd1) && !p1;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      p1    <= 1'b0;
      wt    <= 2'd0;
      pend  <= '0;
      o_vld <= 1'b0;
      o_dat <= '0;
    end else begin
      p1    <= i_vld;
      o_vld <= 1'b0;
      if (emit_sum) begin
        o_vld <= 1'b1;
        o_dat <= sum_rs;
        pend  <= dly[CIDX];
        wt    <= gap2 ? 2'd2 : 2'd1;
      end else if (wt != 2'd0) begin
        wt <= wt - 2'd1;
        if (emit_ctr) begin
          o_vld <= 1'b1;
          o_dat <= pend;
        end
      end
    end
  end

  // R8
  stage_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !o_vld);
  // R1
  stage_sum_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_sum && !flush) |=> o_vld);
  // R6
  stage_ctr_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_ctr && !flush) |=> (o_vld && o_dat == $past(pend)));
  // R9
  stage_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit_sum |-> (wt == 2'd0));
endmodule

// File: rtl/hb_interp_tx.sv
module hb_interp_tx
  import hbi_pkg::*;
#(
  parameter int DW      = 12,
  parameter int CW      = 16,
  parameter int NTAP_S1 = 43,
  parameter int NTAP_S2 = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  output logic          out_vld,
  output logic [DW-1:0] out_data
);
  hb_mode_e             mode_q;
  logic                 flush, en_s1, en_byp, gap2;
  logic                 s1_vld, s2_vld, s2_in;
  logic signed [DW-1:0] s1_dat, s2_dat;
  logic                 sel_vld;
  logic [DW-1:0]        sel_dat;

  hbi_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_vld(in_vld),
    .mode_q(mode_q), .flush(flush), .en_s1(en_s1), .en_byp(en_byp), .gap2(gap2)
  );

  hbi_stage #(.DW(DW), .CW(CW), .NTAP(NTAP_S1), .SEL(0)) u_s1 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .gap2(gap2),
    .i_vld(en_s1), .i_dat(in_data), .o_vld(s1_vld), .o_dat(s1_dat)
  );

  assign s2_in = s1_vld && (mode_q == M_X4);

  hbi_stage #(.DW(DW), .CW(CW), .NTAP(NTAP_S2), .SEL(1)) u_s2 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .gap2(1'b0),
    .i_vld(s2_in), .i_dat(s1_dat), .o_vld(s2_vld), .o_dat(s2_dat)
  );

  always_comb begin
    case (mode_q)
      M_X4:    begin sel_vld = s2_vld; sel_dat = s2_dat;  end
      M_X2:    begin sel_vld = s1_vld; sel_dat = s1_dat;  end
      M_X1:    begin sel_vld = en_byp; sel_dat = in_data; end
      default: begin sel_vld = 1'b0;   sel_dat = '0;      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= sel_vld;
      if (sel_vld) out_data <= sel_dat;
    end
  end

  // R3
  byp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_byp |=> (out_vld && out_data == $past(in_data)));
  // R2
  rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RSV && mode == 2'b11) |=> !out_vld);
  // R8
  top_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_vld);
endmodule

// File: tb/hb_interp_tx_bench.sv
`timescale 1ns/1ps
module hb_interp_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b11;
  logic        in_vld = 1'b0;
  logic [11:0] in_data = '0;
  logic        out_vld;
  logic [11:0] out_data;

  always #2.5 clk = ~clk;

  hb_interp_tx u_hb_interp_tx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_vld(in_vld), .in_data(in_data),
    .out_vld(out_vld), .out_data(out_data)
  );

  int    nchk = 0, nbad = 0, nout = 0, oidx = 0;
  int    peak_val = 0, peak_idx = -1;
  int    expq[$];
  string tagq[$];
  string idle_tag = "R1";
  bit    done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      int v;
      v = int'($signed(out_data));
      if (expq.size() == 0) begin
        check(1'b0, idle_tag, v, 9999);
      end else begin
        int e; string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(v == e, t, v, e);
      end
      if (peak_idx < 0 && v == peak_val) peak_idx = oidx;
      oidx++;
      nout++;
    end
  end

  // bench-side tap set, written as a signed table per stage
  function automatic int tap_of(input int sel, input int i);
    int nt, off, a;
    int t1[11] = '{20751, -6639, 3663, -2294, 1488, -947, 577, -319, 149, -50, 5};
    int t2[3]  = '{19200, -3200, 384};
    nt  = (sel == 0) ? 43 : 11;
    off = i - nt / 2;
    a   = (off < 0) ? -off : off;
    if (off == 0) return 32768;
    if (a % 2 == 0) return 0;
    return (sel == 0) ? t1[(a - 1) / 2] : t2[(a - 1) / 2];
  endfunction

  function automatic int ref_rs(input longint acc);
    longint r, q;
    r = acc + 16384;
    if (r >= 0) q = r / 32768;
    else        q = -((-r + 32767) / 32768);
    if (q > 2047)  q = 2047;
    if (q < -2048) q = -2048;
    return int'(q);
  endfunction

  task automatic ref_interp(input int xs[], input int sel, output int ys[]);
    int nt, n;
    nt = (sel == 0) ? 43 : 11;
    n  = xs.size();
    ys = new[2 * n];
    for (int m = 0; m < 2 * n; m++) begin
      longint acc = 0;
      for (int i = 0; i < nt; i++) begin
        int j = m - i;
        if (j >= 0 && (j % 2) == 0 && (j / 2) < n)
          acc += longint'(tap_of(sel, i)) * longint'(xs[j / 2]);
      end
      ys[m] = ref_rs(acc);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain(input string tag);
    int t = 0;
    while (expq.size() != 0 && t < 3000) begin @(posedge clk); t++; end
    #1;
    check(expq.size() == 0, tag, expq.size(), 0);
    expq.delete(); tagq.delete();
    tick(12);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(posedge clk); #1;
    mode = m;
    tick(3);
  endtask

  // drive one burst at a given spacing pattern and push its expected items
  task automatic run_burst(input logic [1:0] m, input int xs[], input int gap,
                           input bit irregular, input string tag);
    int ys[], y1[], fac, base;
    if (m == 2'b10) begin ys = xs; fac = 1; end
    else if (m == 2'b01) begin ref_interp(xs, 0, ys); fac = 2; end
    else begin ref_interp(xs, 0, y1); ref_interp(y1, 1, ys); fac = 4; end
    foreach (ys[i]) begin expq.push_back(ys[i]); tagq.push_back(tag); end
    oidx = 0; peak_idx = -1; base = nout;
    foreach (xs[i]) begin
      in_vld = 1'b1; in_data = 12'(xs[i]);
      tick(1);
      in_vld = 1'b0;
      tick(gap - 1 + (irregular ? (i % 4) : 0));
    end
    drain(tag);
    // R1: output count per accepted input
    check(nout - base == xs.size() * fac, "R1", nout - base, xs.size() * fac);
  endtask

  function automatic int lfsr_val(input int i);
    int s = 32'h1d2c + i * 7919;
    for (int k = 0; k < 5; k++) s = (s * 1103515245 + 12345) & 32'h7fffffff;
    return ((s >>> 8) % 4096) - 2048;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int xs[], imp[];
    // R10: reset state
    tick(3);
    check(out_vld == 1'b0, "R10", int'(out_vld), 0);
    rst_n = 1'b1;
    tick(1);
    check(out_vld == 1'b0, "R10", int'(out_vld), 0);

    // R2: reserved code ignores strobes
    begin
      int b;
      idle_tag = "R2";
      b = nout;
      for (int i = 0; i < 6; i++) begin
        in_vld = 1'b1; in_data = 12'(500 + i); tick(1); in_vld = 1'b0; tick(2);
      end
      tick(10);
      check(nout == b, "R2", nout - b, 0);
      idle_tag = "R1";
    end

    // R3: bypass, back-to-back strobes and one-clock latency
    set_mode(2'b10);
    xs = new[20];
    foreach (xs[i]) xs[i] = lfsr_val(i);
    run_burst(2'b10, xs, 1, 1'b0, "R3");
    in_vld = 1'b1; in_data = 12'(-777);
    expq.push_back(-777); tagq.push_back("R3");
    @(negedge clk);
    check(out_vld == 1'b0, "R3", int'(out_vld), 0);
    @(posedge clk); #1; in_vld = 1'b0;
    @(negedge clk);
    check(out_vld == 1'b1, "R3", int'(out_vld), 1);
    drain("R3");

    // R6: impulse latency in each setting
    imp = new[32];
    foreach (imp[i]) imp[i] = 0;
    imp[0] = 1000;
    set_mode(2'b11); set_mode(2'b10);
    peak_val = 1000;
    run_burst(2'b10, imp, 1, 1'b0, "R6");
    check(peak_idx == 0, "R6", peak_idx, 0);
    set_mode(2'b11); set_mode(2'b01);
    run_burst(2'b01, imp, 2, 1'b0, "R6");
    check(peak_idx == 21, "R6", peak_idx, 21);
    set_mode(2'b11); set_mode(2'b00);
    run_burst(2'b00, imp, 4, 1'b0, "R6");
    check(peak_idx == 47, "R6", peak_idx, 47);
    peak_val = 100000;

    // R4: 2x general pattern at minimum spacing
    set_mode(2'b11); set_mode(2'b01);
    xs = new[48];
    foreach (xs[i]) xs[i] = (i < 36) ? lfsr_val(i + 100) : 0;
    run_burst(2'b01, xs, 2, 1'b0, "R4");

    // R9: same data, irregular spacing, fresh start
    set_mode(2'b11); set_mode(2'b01);
    run_burst(2'b01, xs, 2, 1'b1, "R9");

    // R5: 4x general pattern at minimum spacing, then irregular
    set_mode(2'b11); set_mode(2'b00);
    xs = new[40];
    foreach (xs[i]) xs[i] = (i < 28) ? lfsr_val(i + 300) : 0;
    run_burst(2'b00, xs, 4, 1'b0, "R5");
    set_mode(2'b11); set_mode(2'b00);
    run_burst(2'b00, xs, 4, 1'b1, "R9");

    // R7: sign-matched full-scale pattern drives both stages into clamping
    xs = new[48];
    foreach (xs[i]) begin
      if (i < 22) begin
        int j, k;
        j = 21 - i;
        k = (j <= 10) ? 10 - j : j - 11;
        xs[i] = (k % 2 == 0) ? 2047 : -2048;
      end else xs[i] = 0;
    end
    begin
      int ys[], hit = 0;
      ref_interp(xs, 0, ys);
      foreach (ys[i]) if (ys[i] == 2047 || ys[i] == -2048) hit++;
      check(hit > 22, "R7", hit, 23);
    end
    set_mode(2'b11); set_mode(2'b01);
    run_burst(2'b01, xs, 2, 1'b0, "R7");
    foreach (xs[i]) xs[i] = (xs[i] == 2047) ? -2048 : ((xs[i] == -2048) ? 2047 : 0);
    set_mode(2'b11); set_mode(2'b00);
    run_burst(2'b00, xs, 4, 1'b0, "R7");

    // R8: mode change with a strobe in the same cycle after leaving history behind
    set_mode(2'b11); set_mode(2'b01);
    xs = new[10];
    foreach (xs[i]) xs[i] = 1500 - 250 * (i % 3);
    run_burst(2'b01, xs, 2, 1'b0, "R8");
    for (int i = 0; i < 32; i++) begin expq.push_back(0); tagq.push_back("R8"); end
    @(posedge clk); #1;
    mode = 2'b00; in_vld = 1'b1; in_data = 12'(1500);
    tick(1);
    in_vld = 1'b0;
    tick(3);
    for (int i = 0; i < 8; i++) begin
      in_vld = 1'b1; in_data = '0; tick(1); in_vld = 1'b0; tick(3);
    end
    drain("R8");

    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule